// File: doc/BRIEF.md
# Compact register-operation decoder and executor

This unit takes one 16-bit instruction word per clock, recognises a small family of register operations, and produces the write-back for it. The family is: load of an 8-bit immediate, move between low registers, move that can reach the upper eight registers, multiply, bitwise complement, two's-complement negation and bitwise OR. The surrounding core supplies the instruction word, the value of the destination register, the value of the source register and the current condition flags. One clock later the unit returns the destination index, a write strobe, the result, the next flag values and a flag that marks words outside the family or operand choices with undefined outcome.

Each operation has its own rule for the flags. Some update only N and Z. The low move also clears C and V. The high move leaves every flag alone. Negation derives C and V from the subtraction. The register file, instruction fetch, shifts and any program-counter effects of a move are handled elsewhere.

Flags are packed as N at bit 3, Z at bit 2, C at bit 1 and V at bit 0, on both `flags_i` and `flags_o`.

Top module: `dp_exec`

## Requirements
- R1: A word with bits [15:11] = 00100 writes the zero-extended value of bits [7:0] to register {0, bits[10:8]}. N and Z follow the result, and C and V keep their input values.
- R2: A word with bits [15:6] = 0001110000 writes the source value to register {0, bits[2:0]}. N and Z follow the result, and C and V both become 0.
- R3: A word with bits [15:8] = 01000110 writes the source value to register {bit 7, bits[2:0]}, and all four flags keep their input values.
- R4: A word that matches R3 but has bits 7 and 6 both 0 still performs the move and raises `bad_o`. Any other R3 word leaves `bad_o` low.
- R5: A word with bits [15:6] = 0100001101 writes the low DATA_W bits of destination times source to register {0, bits[2:0]}. N and Z follow the result, and C and V are kept. `bad_o` is raised exactly when bits [5:3] equal bits [2:0].
- R6: Bits [15:6] = 0100001111 write the complement of the source, and 0100001100 write destination OR source, each to register {0, bits[2:0]}. Both update only N and Z.
- R7: Bits [15:6] = 0100001001 write 0 minus the source to register {0, bits[2:0]}. N and Z follow the result, C is 1 exactly when the source is 0, and V is 1 exactly when the source is the most negative value.
- R8: Any other word gives `wr_en_o` = 0, `result_o` = 0 and `rd_idx_o` = 0, raises `bad_o`, and returns the input flags unchanged.
- R9: While `rst_ni` is low, every output is 0.
- R10: All outputs are registered: each reflects the inputs sampled at the previous rising clock edge, so back-to-back words each produce their own result one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_i | input | 16 | Instruction word |
| src_a_i | input | DATA_W | Value of the destination register (first operand of multiply and OR) |
| src_b_i | input | DATA_W | Value of the source register |
| flags_i | input | 4 | Current flags {N, Z, C, V} |
| rd_idx_o | output | 4 | Destination register index |
| wr_en_o | output | 1 | Write strobe for the destination |
| result_o | output | DATA_W | Value to write |
| flags_o | output | 4 | Next flags {N, Z, C, V} |
| bad_o | output | 1 | Word is outside the family, or its operands give an undefined outcome |

## Verification
The bench builds the unit with its default DATA_W of 32. At that width the sign bit sits at bit 31, so negating 0x80000000 exercises signed overflow and negating 0 exercises the no-borrow carry. A 32-bit product is also wide enough that random multiplies overflow and truncation is tested. Random words are drawn across all seven opcode classes and the undecoded space. Directed words cover high moves for each H-bit combination, multiplies with the same register in both fields, and a zero immediate.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int IDX_W   = 4;
  localparam int INSTR_W = 16;
  localparam int FLAG_W  = 4;

  // flag vector positions
  localparam int FL_N = 3;
  localparam int FL_Z = 2;
  localparam int FL_C = 1;
  localparam int FL_V = 0;

  // opcode prefixes
  localparam logic [4:0] PFX_MOVI = 5'b00100;
  localparam logic [9:0] PFX_MOVL = 10'b0001110000;
  localparam logic [7:0] PFX_MOVH = 8'b01000110;
  localparam logic [9:0] PFX_MUL  = 10'b0100001101;
  localparam logic [9:0] PFX_MVN  = 10'b0100001111;
  localparam logic [9:0] PFX_ORR  = 10'b0100001100;
  localparam logic [9:0] PFX_NEG  = 10'b0100001001;

  typedef enum logic [2:0] {
    OP_NONE, OP_MOVI, OP_MOVL, OP_MOVH, OP_MUL, OP_MVN, OP_NEG, OP_ORR
  } op_e;

  typedef enum logic [1:0] {
    FM_KEEP, FM_CLEAR, FM_CALC
  } fmode_e;

  typedef struct packed {
    op_e              op;
    logic             wr;
    logic [IDX_W-1:0] rd;
    logic [7:0]       imm;
    logic             bad;
    logic             upd_nz;
    fmode_e           c_md;
    fmode_e           v_md;
  } ctrl_t;
endpackage

// File: rtl/dp_decode.sv
module dp_decode
  import dp_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output ctrl_t              ctrl_o
);
  logic [2:0] fld_lo;
  logic [2:0] fld_mid;
  logic       h1;
  logic       h2;

  assign fld_lo  = instr_i[2:0];
  assign fld_mid = instr_i[5:3];
  assign h1      = instr_i[7];
  assign h2      = instr_i[6];

  always_comb begin
    ctrl_o        = '0;
    ctrl_o.op     = OP_NONE;
    ctrl_o.bad    = 1'b1;
    ctrl_o.c_md   = FM_KEEP;
    ctrl_o.v_md   = FM_KEEP;
    ctrl_o.imm    = instr_i[7:0];
    if (instr_i[15:11] == PFX_MOVI) begin
      ctrl_o.op     = OP_MOVI;
      ctrl_o.wr     = 1'b1;
      ctrl_o.rd     = {1'b0, instr_i[10:8]};
      ctrl_o.bad    = 1'b0;
      ctrl_o.upd_nz = 1'b1;
    end else if (instr_i[15:6] == PFX_MOVL) begin
      ctrl_o.op     = OP_MOVL;
      ctrl_o.wr     = 1'b1;
      ctrl_o.rd     = {1'b0, fld_lo};
      ctrl_o.bad    = 1'b0;
      ctrl_o.upd_nz = 1'b1;
      ctrl_o.c_md   = FM_CLEAR;
      ctrl_o.v_md   = FM_CLEAR;
    end else if (instr_i[15:8] == PFX_MOVH) begin
      ctrl_o.op     = OP_MOVH;
      ctrl_o.wr     = 1'b1;
      ctrl_o.rd     = {h1, fld_lo};
      ctrl_o.bad    = ~(h1 | h2);
    end else if (instr_i[15:6] == PFX_MUL) begin
      ctrl_o.op     = OP_MUL;
      ctrl_o.wr     = 1'b1;
      ctrl_o.rd     = {1'b0, fld_lo};
      ctrl_o.bad    = (fld_mid == fld_lo);
      ctrl_o.upd_nz = 1'b1;
    end else if (instr_i[15:6] == PFX_MVN) begin
      ctrl_o.op     = OP_MVN;
      ctrl_o.wr     = 1'b1;
      ctrl_o.rd     = {1'b0, fld_lo};
      ctrl_o.bad    = 1'b0;
      ctrl_o.upd_nz = 1'b1;
    end else if (instr_i[15:6] == PFX_ORR) begin
      ctrl_o.op     = OP_ORR;
      ctrl_o.wr     = 1'b1;
      ctrl_o.rd     = {1'b0, fld_lo};
      ctrl_o.bad    = 1'b0;
      ctrl_o.upd_nz = 1'b1;
    end else if (instr_i[15:6] == PFX_NEG) begin
      ctrl_o.op     = OP_NEG;
      ctrl_o.wr     = 1'b1;
      ctrl_o.rd     = {1'b0, fld_lo};
      ctrl_o.bad    = 1'b0;
      ctrl_o.upd_nz = 1'b1;
      ctrl_o.c_md   = FM_CALC;
      ctrl_o.v_md   = FM_CALC;
    end
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [7:0]        imm_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              v_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] prod;
  logic [DATA_W:0]   diff;

  assign prod = a_i * b_i;
  assign diff = {1'b0, {DATA_W{1'b0}}} - {1'b0, b_i};

  always_comb begin
    res_o = '0;
    unique case (op_i)
      OP_MOVI: res_o = {{(DATA_W-8){1'b0}}, imm_i};
      OP_MOVL,
      OP_MOVH: res_o = b_i;
      OP_MUL:  res_o = prod;
      OP_MVN:  res_o = ~b_i;
      OP_ORR:  res_o = a_i | b_i;
      OP_NEG:  res_o = diff[MSB:0];
      default: res_o = '0;
    endcase
  end

  // carry is the inverted borrow; overflow only when both operand and result are negative
  assign c_o = ~diff[DATA_W];
  assign v_o = b_i[MSB] & diff[MSB];
endmodule

// File: rtl/dp_flags.sv
module dp_flags
  import dp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              upd_nz_i,
  input  fmode_e            c_md_i,
  input  fmode_e            v_md_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              c_i,
  input  logic              v_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic n_new;
  logic z_new;

  assign n_new = res_i[DATA_W-1];
  assign z_new = (res_i == '0);

  function automatic logic pick(fmode_e md, logic cur, logic calc);
    case (md)
      FM_CLEAR: return 1'b0;
      FM_CALC:  return calc;
      default:  return cur;
    endcase
  endfunction

  always_comb begin
    flags_o       = flags_i;
    flags_o[FL_N] = upd_nz_i ? n_new : flags_i[FL_N];
    flags_o[FL_Z] = upd_nz_i ? z_new : flags_i[FL_Z];
    flags_o[FL_C] = pick(c_md_i, flags_i[FL_C], c_i);
    flags_o[FL_V] = pick(v_md_i, flags_i[FL_V], v_i);
  end
endmodule

// File: rtl/dp_exec.sv
module dp_exec
  import dp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [INSTR_W-1:0]     instr_i,
  input  logic [DATA_W-1:0]      src_a_i,
  input  logic [DATA_W-1:0]      src_b_i,
  input  logic [FLAG_W-1:0]      flags_i,
  output logic [IDX_W-1:0]       rd_idx_o,
  output logic                   wr_en_o,
  output logic [DATA_W-1:0]      result_o,
  output logic [FLAG_W-1:0]      flags_o,
  output logic                   bad_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] alu_res;
  logic              alu_c;
  logic              alu_v;
  logic [FLAG_W-1:0] flags_nxt;

  dp_decode u_dec (
    .instr_i (instr_i),
    .ctrl_o  (ctrl)
  );

  dp_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (ctrl.op),
    .a_i   (src_a_i),
    .b_i   (src_b_i),
    .imm_i (ctrl.imm),
    .res_o (alu_res),
    .c_o   (alu_c),
    .v_o   (alu_v)
  );

  dp_flags #(.DATA_W(DATA_W)) u_flg (
    .upd_nz_i (ctrl.upd_nz),
    .c_md_i   (ctrl.c_md),
    .v_md_i   (ctrl.v_md),
    .res_i    (alu_res),
    .c_i      (alu_c),
    .v_i      (alu_v),
    .flags_i  (flags_i),
    .flags_o  (flags_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_idx_o <= '0;
      wr_en_o  <= 1'b0;
      result_o <= '0;
      flags_o  <= '0;
      bad_o    <= 1'b0;
    end else begin
      rd_idx_o <= ctrl.rd;
      wr_en_o  <= ctrl.wr;
      result_o <= alu_res;
      flags_o  <= flags_nxt;
      bad_o    <= ctrl.bad;
    end
  end
endmodule

// File: rtl/dp_exec_chk.sv
module dp_exec_chk
  import dp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [INSTR_W-1:0]  instr_i,
  input logic [DATA_W-1:0]   src_b_i,
  input logic [FLAG_W-1:0]   flags_i,
  input logic                wr_en_o,
  input logic [DATA_W-1:0]   result_o,
  input logic [FLAG_W-1:0]   flags_o,
  input logic                bad_o
);
  logic seen_q;
  logic known;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assign known = (instr_i[15:11] == PFX_MOVI) || (instr_i[15:6] == PFX_MOVL) ||
                 (instr_i[15:8] == PFX_MOVH) || (instr_i[15:6] == PFX_MUL)  ||
                 (instr_i[15:6] == PFX_MVN)  || (instr_i[15:6] == PFX_ORR)  ||
                 (instr_i[15:6] == PFX_NEG);

  AST_HMOVE_FLAGS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(instr_i[15:8] == PFX_MOVH) |-> flags_o == $past(flags_i)); // R3

  AST_LOWMOVE_CV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(instr_i[15:6] == PFX_MOVL) |-> flags_o[1:0] == 2'b00); // R2

  AST_NEG_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(instr_i[15:6] == PFX_NEG) |-> flags_o[FL_C] == ($past(src_b_i) == '0)); // R7

  AST_UNKNOWN_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(!known) |-> !wr_en_o && bad_o && flags_o == $past(flags_i)); // R8

  AST_MOVI_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(instr_i[15:11] == PFX_MOVI) |-> flags_o[FL_Z] == (result_o == '0)); // R1

  AST_HMOVE_LOW_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(instr_i[15:8] == PFX_MOVH) |-> bad_o == $past(instr_i[7:6] == 2'b00)); // R4
endmodule

bind dp_exec dp_exec_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/dp_exec_tb.sv
`timescale 1ns/1ps
module dp_exec_tb;
  localparam int DW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [15:0]   instr_i = '0;
  logic [DW-1:0] src_a_i = '0;
  logic [DW-1:0] src_b_i = '0;
  logic [3:0]    flags_i = '0;
  logic [3:0]    rd_idx_o;
  logic          wr_en_o;
  logic [DW-1:0] result_o;
  logic [3:0]    flags_o;
  logic          bad_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  dp_exec #(.DATA_W(DW)) u_dut (.*);

  typedef struct packed {
    logic          wr;
    logic [3:0]    rd;
    logic [DW-1:0] res;
    logic [3:0]    fl;
    logic          bad;
  } exp_t;

  string cur_req;

  function automatic exp_t model(logic [15:0] w, logic [DW-1:0] a, logic [DW-1:0] b,
                                 logic [3:0] f, output string req);
    exp_t e;
    logic nz;
    e = '0; e.fl = f; nz = 1'b0; req = "R8";
    if (w[15:11] == 5'b00100) begin
      req = "R1"; e.wr = 1; e.rd = {1'b0, w[10:8]}; e.res = DW'(w[7:0]); nz = 1;
    end else if (w[15:6] == 10'b0001110000) begin
      req = "R2"; e.wr = 1; e.rd = {1'b0, w[2:0]}; e.res = b; nz = 1; e.fl[1:0] = 2'b00;
    end else if (w[15:8] == 8'b01000110) begin
      req = (w[7:6] == 2'b00) ? "R4" : "R3";
      e.wr = 1; e.rd = {w[7], w[2:0]}; e.res = b; e.bad = (w[7:6] == 2'b00);
    end else if (w[15:6] == 10'b0100001101) begin
      req = "R5"; e.wr = 1; e.rd = {1'b0, w[2:0]}; e.res = a * b; nz = 1;
      e.bad = (w[5:3] == w[2:0]);
    end else if (w[15:6] == 10'b0100001111) begin
      req = "R6"; e.wr = 1; e.rd = {1'b0, w[2:0]}; e.res = ~b; nz = 1;
    end else if (w[15:6] == 10'b0100001100) begin
      req = "R6"; e.wr = 1; e.rd = {1'b0, w[2:0]}; e.res = a | b; nz = 1;
    end else if (w[15:6] == 10'b0100001001) begin
      req = "R7"; e.wr = 1; e.rd = {1'b0, w[2:0]}; e.res = -b; nz = 1;
      e.fl[1] = (b == 0);
      e.fl[0] = (b == {1'b1, {(DW-1){1'b0}}});
    end else begin
      e.bad = 1;
    end
    if (nz) begin
      e.fl[3] = e.res[DW-1];
      e.fl[2] = (e.res == 0);
    end
    return e;
  endfunction

  task automatic cmp(string req, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // drive on a falling edge, check on the next falling edge (one register stage)
  task automatic run(logic [15:0] w, logic [DW-1:0] a, logic [DW-1:0] b, logic [3:0] f,
                     string tag = "");
    exp_t e;
    string req;
    instr_i = w; src_a_i = a; src_b_i = b; flags_i = f;
    e = model(w, a, b, f, req);
    if (tag != "") req = tag;
    @(negedge clk_i);
    cmp(req, "wr_en", DW'(wr_en_o), DW'(e.wr));
    cmp(req, "bad",   DW'(bad_o),   DW'(e.bad));
    cmp(req, "flags", DW'(flags_o), DW'(e.fl));
    if (e.wr) begin
      cmp(req, "rd", DW'(rd_idx_o), DW'(e.rd));
      cmp(req, "result", result_o, e.res);
    end else begin
      cmp(req, "rd_idle", DW'(rd_idx_o), '0);
      cmp(req, "res_idle", result_o, '0);
    end
  endtask

  function automatic logic [DW-1:0] pick_val();
    case ($urandom % 6)
      0: return '0;
      1: return {1'b1, {(DW-1){1'b0}}};
      2: return '1;
      default: return DW'($urandom);
    endcase
  endfunction

  function automatic logic [15:0] pick_word();
    logic [15:0] r;
    r = 16'($urandom);
    case ($urandom % 9)
      0: return {5'b00100, r[10:0]};
      1: return {10'b0001110000, r[5:0]};
      2: return {8'b01000110, r[7:0]};
      3: return {10'b0100001101, r[5:0]};
      4: return {10'b0100001111, r[5:0]};
      5: return {10'b0100001100, r[5:0]};
      6: return {10'b0100001001, r[5:0]};
      default: return r;
    endcase
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    instr_i = 16'h2001; src_b_i = 32'h1234; flags_i = 4'hF;
    repeat (3) @(negedge clk_i);
    // R9: reset holds every output at zero
    cmp("R9", "wr_en", DW'(wr_en_o), '0);
    cmp("R9", "result", result_o, '0);
    cmp("R9", "flags", DW'(flags_o), '0);
    cmp("R9", "bad", DW'(bad_o), '0);
    cmp("R9", "rd", DW'(rd_idx_o), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed corners
    run(16'h2500, 32'h5, 32'h7, 4'b0011);                 // R1 zero immediate -> Z
    run(16'h27FF, 32'h0, 32'h0, 4'b1100);                 // R1 keeps C,V
    run(16'h1C0A, 32'h0, 32'h8000_0001, 4'b0011);         // R2 clears C,V
    run(16'h4600, 32'h0, 32'hDEAD_BEEF, 4'b1010);         // R4 H1=H2=0
    run(16'h4681, 32'h0, 32'h0, 4'b0101);                 // R3 H1 only
    run(16'h4647, 32'h0, 32'h1, 4'b1111);                 // R3 H2 only
    run(16'h46C5, 32'h0, 32'h42, 4'b0000);                // R3 both
    run(16'h4352, 32'h0001_0000, 32'h0001_0000, 4'b0011); // R5 product wraps to 0
    run(16'h4349, 32'h3, 32'h3, 4'b0000);                 // R5 same register
    run(16'h4240, 32'h9, 32'h0, 4'b1111);                 // R7 negate zero
    run(16'h4241, 32'h9, 32'h8000_0000, 4'b0000);         // R7 negate minimum
    run(16'h4242, 32'h0, 32'h1, 4'b0000);                 // R7 negate one
    run(16'h43C3, 32'h0, 32'hFFFF_FFFF, 4'b0011);         // R6 NOT to zero
    run(16'h4304, 32'h00F0, 32'h0F00, 4'b0011);           // R6 OR
    run(16'hFFFF, 32'h1, 32'h2, 4'b1001);                 // R8 undecoded
    run(16'h4200, 32'h1, 32'h2, 4'b0110);                 // R8 undecoded AND-like slot
    // R10: back-to-back words each appear one cycle later
    run(16'h20AA, 32'h0, 32'h0, 4'b0000, "R10");
    run(16'h43C0, 32'h0, 32'h1234_5678, 4'b0000, "R10");

    for (int i = 0; i < 3000; i++)
      run(pick_word(), pick_val(), pick_val(), 4'($urandom));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule